// File: doc/BRIEF.md
# UART Bit-Rate and Receive-Timeout Generator

This block sets the bit timing of a UART. A source clock is chosen by a mode bit: either the system clock or the system clock divided by eight. A 16-bit clock divisor turns that source into a sample tick. A bit divisor then groups sample ticks into one bit tick. The serializer and the deserializer step on `bit_tick`. They can also oversample on `sample_tick`.

The mode register also gives the character frame: data width, parity and stop bits. From these fields the block reports the frame length in bits. It uses that length to time a receive timeout. The deserializer pulses `rx_byte` for each byte it accepts. If no further byte arrives within four character times, and the timeout register is nonzero, `rx_timeout` pulses once. Writes to the divisors that would give an unusable divisor are dropped silently.

All configuration goes through one write strobe with a 2-bit register select.

Top module: `uart_baud_gen`

## Requirements
- R1: When mode bit 0 is 1, the source clock runs at one eighth of `clk`. When mode bit 0 is 0, the source clock is `clk` itself.
- R2: In steady state, `bit_tick` pulses once every P × clock_divisor × (bit_divisor + 1) cycles of `clk`. P is 8 when the prescaler is selected and 1 otherwise.
- R3: A write with `wr_sel`=1 updates the clock divisor only if the full `wr_data` value is at least 1. Only `wr_data[15:0]` is kept. The clock divisor holds its value at all other times.
- R4: A write with `wr_sel`=2 updates the bit divisor only if the full `wr_data` value is at least 4. Only `wr_data[7:0]` is kept.
- R5: After reset, the clock divisor is 0x28B, the bit divisor is 0xF and the mode register is 0. With mode 0 the reported frame length is 12.
- R6: The mode register is written with `wr_sel`=0 and keeps `wr_data[7:0]`. Mode bits 2:1 give the data width: 3 means 6 bits, 2 means 7 bits, and any other value means 8 bits.
- R7: Mode bits 5:3 equal to 0 (even parity) or 1 (odd parity) add one parity bit; any other value adds none. Mode bits 7:6 equal to 3 give one stop bit; any other value gives two.
- R8: `char_len_o` equals 1 + data bits + parity bit + stop bits.
- R9: `sample_tick` pulses once every clock_divisor source ticks. `bit_tick` follows after every bit_divisor + 1 sample ticks.
- R10: The timeout register is written with `wr_sel`=3 and keeps `wr_data[7:0]`. While it is nonzero, `rx_timeout` pulses for one cycle once 4 × `char_len_o` bit ticks have passed since the most recent `rx_byte`. Each new `rx_byte` restarts that count.
- R11: While the timeout register is zero, `rx_timeout` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 mode, 1 clock divisor, 2 bit divisor, 3 timeout |
| wr_data | input | 32 | Write data |
| rx_byte | input | 1 | One-cycle pulse for each received byte |
| sample_tick | output | 1 | Sample-rate pulse |
| bit_tick | output | 1 | Bit-rate pulse |
| rx_timeout | output | 1 | Receive-timeout pulse |
| clk_div_o | output | 16 | Current clock divisor |
| bit_div_o | output | 8 | Current bit divisor |
| char_len_o | output | 4 | Frame length in bits |

## Verification
The bench tries writes that must be refused: a zero clock divisor and a bit divisor of 3. A design that took them would slow the tick or stall it. The bench also writes values above the field width, which a design without truncation would store in error.

Tick periods are measured with and without the prescaler. The bench counts the sample ticks inside each bit. An off-by-one in either counter changes both numbers.

For the timeout, the bench counts bit ticks from the last byte to the pulse, including a case where a second byte arrives partway through. A design that does not restart the count would fire early. The bench also checks that a zero timeout register keeps the output silent.

// File: rtl/uart_bg_pkg.sv
package uart_bg_pkg;

    localparam int MODE_W = 8;
    localparam int LEN_W  = 4;

    typedef enum logic [1:0] {
        SEL_MODE   = 2'd0,
        SEL_CLKDIV = 2'd1,
        SEL_BITDIV = 2'd2,
        SEL_TMO    = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [1:0] stop_f;
        logic [2:0] par_f;
        logic [1:0] width_f;
        logic       presc;
    } mode_t;

    function automatic logic [LEN_W-1:0] data_bits(input logic [1:0] f);
        case (f)
            2'd3:    return LEN_W'(6);
            2'd2:    return LEN_W'(7);
            default: return LEN_W'(8);
        endcase
    endfunction

    function automatic logic [LEN_W-1:0] frame_bits(input mode_t m);
        logic [LEN_W-1:0] n;
        n = LEN_W'(1) + data_bits(m.width_f);
        if (m.par_f <= 3'd1)
            n = n + LEN_W'(1);
        n = n + ((m.stop_f == 2'd3) ? LEN_W'(1) : LEN_W'(2));
        return n;
    endfunction

endpackage

// File: rtl/uart_bg_regs.sv
module uart_bg_regs
    import uart_bg_pkg::*;
#(
    parameter int                DIV_W      = 16,
    parameter int                BDIV_W     = 8,
    parameter int                TO_W       = 8,
    parameter int                WR_W       = 32,
    parameter int                CLKDIV_MIN = 1,
    parameter int                BITDIV_MIN = 4,
    parameter logic [DIV_W-1:0]  CLKDIV_RST = 16'h028B,
    parameter logic [BDIV_W-1:0] BITDIV_RST = 8'h0F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [WR_W-1:0]   wr_data,
    output mode_t             mode_q,
    output logic [DIV_W-1:0]  clk_div_q,
    output logic [BDIV_W-1:0] bit_div_q,
    output logic [TO_W-1:0]   tmo_q,
    output logic              restart
);

    logic mode_wr, clk_ok, bit_ok, tmo_wr;

    always_comb begin
        mode_wr = wr_en && (reg_sel_e'(wr_sel) == SEL_MODE);
        clk_ok  = wr_en && (reg_sel_e'(wr_sel) == SEL_CLKDIV) && (wr_data >= WR_W'(CLKDIV_MIN));
        bit_ok  = wr_en && (reg_sel_e'(wr_sel) == SEL_BITDIV) && (wr_data >= WR_W'(BITDIV_MIN));
        tmo_wr  = wr_en && (reg_sel_e'(wr_sel) == SEL_TMO);
        restart = mode_wr || clk_ok || bit_ok;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= '0;
            clk_div_q <= CLKDIV_RST;
            bit_div_q <= BITDIV_RST;
            tmo_q     <= '0;
        end else begin
            if (mode_wr) mode_q    <= mode_t'(wr_data[MODE_W-1:0]);
            if (clk_ok)  clk_div_q <= wr_data[DIV_W-1:0];
            if (bit_ok)  bit_div_q <= wr_data[BDIV_W-1:0];
            if (tmo_wr)  tmo_q     <= wr_data[TO_W-1:0];
        end
    end

endmodule

// File: rtl/uart_bg_rate.sv
module uart_bg_rate #(
    parameter int DIV_W  = 16,
    parameter int BDIV_W = 8,
    parameter int PRESC  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              presc_sel,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic [BDIV_W-1:0] bit_div,
    output logic              sample_tick,
    output logic              bit_tick
);

    localparam int PRE_W = (PRESC > 1) ? $clog2(PRESC) : 1;

    logic src_en;

    generate
        if (PRESC > 1) begin : g_pre
            logic [PRE_W-1:0] pre_cnt;
            always_ff @(posedge clk) begin
                if (rst || restart)
                    pre_cnt <= '0;
                else if (pre_cnt == PRE_W'(PRESC - 1))
                    pre_cnt <= '0;
                else
                    pre_cnt <= pre_cnt + PRE_W'(1);
            end
            assign src_en = presc_sel ? (pre_cnt == PRE_W'(PRESC - 1)) : 1'b1;
        end else begin : g_nopre
            assign src_en = 1'b1;
        end
    endgenerate

    logic [DIV_W-1:0]  s_cnt;
    logic [BDIV_W-1:0] b_cnt;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            s_cnt       <= '0;
            sample_tick <= 1'b0;
        end else if (src_en) begin
            if (s_cnt <= DIV_W'(1)) begin
                s_cnt       <= clk_div;
                sample_tick <= 1'b1;
            end else begin
                s_cnt       <= s_cnt - DIV_W'(1);
                sample_tick <= 1'b0;
            end
        end else begin
            sample_tick <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            b_cnt    <= '0;
            bit_tick <= 1'b0;
        end else if (sample_tick) begin
            if (b_cnt >= bit_div) begin
                b_cnt    <= '0;
                bit_tick <= 1'b1;
            end else begin
                b_cnt    <= b_cnt + BDIV_W'(1);
                bit_tick <= 1'b0;
            end
        end else begin
            bit_tick <= 1'b0;
        end
    end

endmodule

// File: rtl/uart_bg_timeout.sv
module uart_bg_timeout #(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_byte,
    input  logic             bit_tick,
    input  logic             tmo_en,
    input  logic [LEN_W-1:0] char_len,
    output logic             rx_timeout
);

    localparam int CNT_W = LEN_W + 2;

    logic             armed;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] target;

    assign target = {char_len, 2'b00};

    always_ff @(posedge clk) begin
        if (rst) begin
            armed      <= 1'b0;
            cnt        <= '0;
            rx_timeout <= 1'b0;
        end else begin
            rx_timeout <= 1'b0;
            if (rx_byte) begin
                armed <= 1'b1;
                cnt   <= '0;
            end else if (armed && bit_tick) begin
                if (cnt + CNT_W'(1) >= target) begin
                    armed      <= 1'b0;
                    cnt        <= '0;
                    rx_timeout <= tmo_en;
                end else begin
                    cnt <= cnt + CNT_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen
    import uart_bg_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int BDIV_W = 8,
    parameter int TO_W   = 8,
    parameter int WR_W   = 32,
    parameter int PRESC  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [WR_W-1:0]   wr_data,
    input  logic              rx_byte,
    output logic              sample_tick,
    output logic              bit_tick,
    output logic              rx_timeout,
    output logic [DIV_W-1:0]  clk_div_o,
    output logic [BDIV_W-1:0] bit_div_o,
    output logic [LEN_W-1:0]  char_len_o
);

    mode_t           mode_q;
    logic [TO_W-1:0] tmo_q;
    logic            restart;

    uart_bg_regs #(
        .DIV_W  (DIV_W),
        .BDIV_W (BDIV_W),
        .TO_W   (TO_W),
        .WR_W   (WR_W)
    ) regs_i (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .mode_q    (mode_q),
        .clk_div_q (clk_div_o),
        .bit_div_q (bit_div_o),
        .tmo_q     (tmo_q),
        .restart   (restart)
    );

    assign char_len_o = frame_bits(mode_q);

    uart_bg_rate #(
        .DIV_W  (DIV_W),
        .BDIV_W (BDIV_W),
        .PRESC  (PRESC)
    ) rate_i (
        .clk         (clk),
        .rst         (rst),
        .restart     (restart),
        .presc_sel   (mode_q.presc),
        .clk_div     (clk_div_o),
        .bit_div     (bit_div_o),
        .sample_tick (sample_tick),
        .bit_tick    (bit_tick)
    );

    uart_bg_timeout #(
        .LEN_W (LEN_W)
    ) tmo_i (
        .clk        (clk),
        .rst        (rst),
        .rx_byte    (rx_byte),
        .bit_tick   (bit_tick),
        .tmo_en     (tmo_q != '0),
        .char_len   (char_len_o),
        .rx_timeout (rx_timeout)
    );

endmodule

// File: rtl/uart_baud_gen_chk.sv
module uart_baud_gen_chk #(
    parameter int DIV_W  = 16,
    parameter int BDIV_W = 8,
    parameter int TO_W   = 8,
    parameter int WR_W   = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [1:0]        wr_sel,
    input logic [WR_W-1:0]   wr_data,
    input logic              rx_byte,
    input logic              sample_tick,
    input logic              bit_tick,
    input logic              rx_timeout,
    input logic [DIV_W-1:0]  clk_div,
    input logic [BDIV_W-1:0] bit_div,
    input logic [TO_W-1:0]   tmo_val
);

    // R3
    clkdiv_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd1 && wr_data == '0) |=> $stable(clk_div));

    // R3
    clkdiv_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_sel == 2'd1) |=> $stable(clk_div));

    // R4
    bitdiv_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd2 && wr_data < WR_W'(4)) |=> $stable(bit_div));

    // R9
    bit_after_sample_chk: assert property (@(posedge clk) disable iff (rst)
        bit_tick |-> $past(sample_tick));

    // R10
    timeout_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        rx_timeout |-> ($past(bit_tick) && !$past(rx_byte)));

    // R11
    timeout_enabled_chk: assert property (@(posedge clk) disable iff (rst)
        rx_timeout |-> ($past(tmo_val) != '0));

endmodule

bind uart_baud_gen uart_baud_gen_chk #(
    .DIV_W  (DIV_W),
    .BDIV_W (BDIV_W),
    .TO_W   (TO_W),
    .WR_W   (WR_W)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_data     (wr_data),
    .rx_byte     (rx_byte),
    .sample_tick (sample_tick),
    .bit_tick    (bit_tick),
    .rx_timeout  (rx_timeout),
    .clk_div     (clk_div_o),
    .bit_div     (bit_div_o),
    .tmo_val     (tmo_q)
);

// File: tb/uart_baud_gen_tb_top.sv
module uart_baud_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic        rx_byte = 1'b0;
    logic        sample_tick, bit_tick, rx_timeout;
    logic [15:0] clk_div_o;
    logic [7:0]  bit_div_o;
    logic [3:0]  char_len_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    uart_baud_gen dut_i (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_sel      (wr_sel),
        .wr_data     (wr_data),
        .rx_byte     (rx_byte),
        .sample_tick (sample_tick),
        .bit_tick    (bit_tick),
        .rx_timeout  (rx_timeout),
        .clk_div_o   (clk_div_o),
        .bit_div_o   (bit_div_o),
        .char_len_o  (char_len_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // scoreboard: expected bit period and sample ticks per bit
    int    exp_per_q[$];
    int    exp_smp_q[$];
    string mon_tag = "";
    bit    mon_clear = 1'b0;
    bit    seen = 1'b0;
    int    cyc = 0;
    int    smp = 0;

    always @(negedge clk) begin
        if (mon_clear) begin
            seen      = 1'b0;
            mon_clear = 1'b0;
        end
        cyc++;
        if (bit_tick) begin
            if (seen && exp_per_q.size() > 0) begin
                int ep, es;
                ep = exp_per_q.pop_front();
                es = exp_smp_q.pop_front();
                check(cyc == ep, {mon_tag, " period"}, cyc, ep);
                check(smp == es, "R9 samples per bit", smp, es);
            end
            seen = 1'b1;
            cyc  = 0;
            smp  = 0;
        end
        if (sample_tick) smp++;
    end

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_sel  = s;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic rate_case(input logic [31:0] mode, input logic [31:0] cd,
                             input logic [31:0] bd, input int per, input int spb,
                             input string tag);
        wr(2'd0, mode);
        wr(2'd1, cd);
        wr(2'd2, bd);
        mon_tag   = tag;
        mon_clear = 1'b1;
        for (int i = 0; i < 3; i++) begin
            exp_per_q.push_back(per);
            exp_smp_q.push_back(spb);
        end
        while (exp_per_q.size() != 0) @(negedge clk);
    endtask

    // Pulse rx_byte, then count bit ticks until rx_timeout (or limit)
    task automatic tmo_run(input int pre_ticks, input int limit, output int n, output bit fired);
        int k;
        @(negedge clk);
        rx_byte = 1'b1;
        @(negedge clk);
        rx_byte = 1'b0;
        k = 0;
        while (k < pre_ticks) begin
            if (bit_tick) k++;
            @(negedge clk);
        end
        if (pre_ticks > 0) begin
            rx_byte = 1'b1;
            @(negedge clk);
            rx_byte = 1'b0;
        end
        n = 0;
        fired = 1'b0;
        while (!fired && n < limit) begin
            if (bit_tick) n++;
            if (rx_timeout) fired = 1'b1;
            else @(negedge clk);
        end
    endtask

    initial begin
        int cycles = 0;
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                check(1'b0, "watchdog", cycles, 150000);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                $finish;
            end
        end
    end

    initial begin
        int  n;
        bit  f;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R5 reset state
        check(clk_div_o == 16'h028B, "R5 clk div reset", clk_div_o, 16'h028B);
        check(bit_div_o == 8'h0F, "R5 bit div reset", bit_div_o, 8'h0F);
        check(char_len_o == 4'd12, "R5 frame len reset", char_len_o, 12);
        check(rx_timeout == 1'b0, "R5 timeout low", rx_timeout, 0);

        // R3 guarded clock divisor
        wr(2'd1, 32'd0);
        check(clk_div_o == 16'h028B, "R3 zero rejected", clk_div_o, 16'h028B);
        wr(2'd1, 32'h0001_0005);
        check(clk_div_o == 16'd5, "R3 low 16 bits kept", clk_div_o, 5);

        // R4 guarded bit divisor
        wr(2'd2, 32'd3);
        check(bit_div_o == 8'h0F, "R4 three rejected", bit_div_o, 8'h0F);
        wr(2'd2, 32'h0000_0104);
        check(bit_div_o == 8'd4, "R4 low 8 bits kept", bit_div_o, 4);
        wr(2'd2, 32'd4);
        check(bit_div_o == 8'd4, "R4 four accepted", bit_div_o, 4);

        // R6 R7 R8 frame length
        wr(2'd0, 32'h0000_00E6);
        check(char_len_o == 4'd8, "R6 six data bits, no parity, one stop", char_len_o, 8);
        wr(2'd0, 32'h0000_0004);
        check(char_len_o == 4'd11, "R6 seven data bits", char_len_o, 11);
        wr(2'd0, 32'h0000_0008);
        check(char_len_o == 4'd12, "R7 odd parity", char_len_o, 12);
        wr(2'd0, 32'h0000_0038);
        check(char_len_o == 4'd11, "R7 no parity", char_len_o, 11);
        wr(2'd0, 32'h0000_00C2);
        check(char_len_o == 4'd11, "R8 one stop, field 1 is 8 bits", char_len_o, 11);

        // R2 R9 bit rates without prescale
        rate_case(32'h0, 32'd3, 32'd4, 15, 5, "R2 div3x5");
        rate_case(32'h0, 32'd1, 32'd5, 6, 6, "R2 div1x6");
        // R1 prescaled source
        rate_case(32'h1, 32'd2, 32'd4, 80, 5, "R1 presc div2x5");

        // R10 timeout: frame 8 bits -> 32 bit ticks
        rate_case(32'hE6, 32'd1, 32'd4, 5, 5, "R2 div1x5");
        wr(2'd3, 32'd5);
        tmo_run(0, 200, n, f);
        check(f, "R10 timeout fired", f, 1);
        check(n == 32, "R10 ticks to timeout", n, 32);
        tmo_run(10, 200, n, f);
        check(f && n == 32, "R10 restart on new byte", n, 32);

        // R11 zero timeout register
        wr(2'd3, 32'h0000_0100);
        tmo_run(0, 40, n, f);
        check(!f, "R11 no timeout when zero", f, 0);
        check(n == 40, "R11 ticks continued", n, 40);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule